// File: doc/BRIEF.md
# Clock Output Mode Select and Stop Gating

This block sits at the output end of a multi-domain clock generator. It turns a three-bit select code into an output mode and then gates eight clock groups. In the normal modes each group passes a clock that arrives on an input. In test mode every group is built from one shared counter. Each group also gets an output-enable, so the pad buffer can float the pin. Two active-low stop inputs park chosen groups low, and a power-up input parks every group low when it is deasserted.

All logic runs on one fast clock `clk`. The group clocks arrive as levels that are sampled on that clock. In test mode `clk` stands in for twice the test reference. The reference group then toggles at clk/2, and each slower group divides further by a power of two. The controller is a small state machine with two states. ST_RUN drives the current mode. ST_SETTLE is entered on every change of mode or CPU rate. It drives all outputs low and enabled for `SETTLE_CYC` cycles before the new mode starts.

Group index order, used on every vector port: 0 CPU, 1 CPU/2, 2 66 MHz, 3 PCI, 4 free-running PCI, 5 48 MHz, 6 reference, 7 APIC. The select vector is `sel[2]` = fast CPU rate, `sel[1]`, `sel[0]`. There are two state transitions. T_CHANGE fires from either state when the decoded mode or `sel[2]` differs from the stored one, and it leads to ST_SETTLE. T_DONE leads from ST_SETTLE to ST_RUN after `SETTLE_CYC` cycles.

Top module: `clk_mode_gate`

## Requirements
- R1: While `rst_n` is low, every `clk_out` bit and every `clk_oe` bit is 0.
- R2: Code 000 (tri-state) and the reserved codes 001 and 101 hold all eight `clk_oe` bits at 0 while power is up.
- R3: Code 100 is test mode. The shared counter restarts at zero on entry. The reference group toggles at clk/2, CPU and 48 MHz at clk/4, CPU/2 and 66 MHz at clk/8, both PCI groups at clk/16, and APIC at clk/32. All enables are 1.
- R4: Codes 010 and 110 enable every group except 48 MHz (index 5), whose enable is 0 and whose output is 0. Codes 011 and 111 enable all eight groups.
- R5: In a normal mode, `sel[2]`=1 makes groups 0 and 1 follow `alt_src[0]` and `alt_src[1]`. `sel[2]`=0 makes them follow `grp_src[0]` and `grp_src[1]`. The other groups are unaffected.
- R6: `pwr_up`=0 sets every `clk_oe` bit to 1 and brings every output to 0, in any mode.
- R7: `cpu_hold_n`=0 holds the CPU and 66 MHz groups low. All other groups keep running.
- R8: `pci_hold_n`=0 holds the PCI group (index 3) low while the free-running PCI group (index 4) keeps toggling.
- R9: A group's gate changes only in a cycle where its source is low, so every high pulse a group emits has the full length of its source's high phase.
- R10: A change of decoded mode or of `sel[2]` drives all outputs to 0 with all enables 1 for `SETTLE_CYC` cycles, starting one edge after the change is seen. The new mode follows.
- R11: When a group is running in a normal mode, its output equals its selected source level one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; doubled test reference in test mode |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 3 | Mode select {fast CPU rate, mode bit 1, mode bit 0} |
| pwr_up | input | 1 | 1 = operate, 0 = park every output low |
| cpu_hold_n | input | 1 | Active-low hold for the CPU and 66 MHz groups |
| pci_hold_n | input | 1 | Active-low hold for the PCI group |
| grp_src | input | 8 | Per-group source clocks for the normal modes |
| alt_src | input | 2 | Fast-rate sources for groups 0 and 1 |
| clk_out | output | 8 | Gated group clocks |
| clk_oe | output | 8 | Per-group output-enable (0 = high impedance) |

## Verification
A source level or stop change reaches `clk_out` on the first edge after it is seen. A closing gate waits for the first edge at which the source is low. Enables follow `pwr_up` and the stored mode one edge later. A select change is stored on the next edge, and the outputs are parked low from the edge after that. The bench's behavioural model steps on each rising edge, using the input values the bench set at the preceding falling edge. The bench compares every output at the following falling edge, so each expected value is due exactly one edge after its cause. The directed ratio, pulse-width and stop windows start several cycles after the last select change, so the settle window is over before any counting begins.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    localparam int NGRP = 8;

    // group indices
    localparam int G_CPU  = 0;
    localparam int G_CPUH = 1;
    localparam int G_M66  = 2;
    localparam int G_PCI  = 3;
    localparam int G_PCIF = 4;
    localparam int G_F48  = 5;
    localparam int G_REF  = 6;
    localparam int G_APIC = 7;

    // largest divider tap used by any group, counter width derived from it
    localparam int MAX_TAP = 4;
    localparam int DIV_W   = MAX_TAP + 1;

    typedef enum logic [2:0] {
        MD_HIZ    = 3'd0,
        MD_RSVD   = 3'd1,
        MD_NORM   = 3'd2,
        MD_NORM48 = 3'd3,
        MD_TEST   = 3'd4
    } mode_e;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_SETTLE = 1'b1
    } fsm_e;

    // counter bit feeding each group in test mode
    function automatic int div_tap(input int g);
        case (g)
            G_REF:           return 0;
            G_CPU, G_F48:    return 1;
            G_CPUH, G_M66:   return 2;
            G_PCI, G_PCIF:   return 3;
            default:         return MAX_TAP;
        endcase
    endfunction

endpackage

// File: rtl/clkgate_decode.sv
module clkgate_decode
    import clkgate_pkg::*;
(
    input  logic [2:0] code,
    output mode_e      mode
);

    always_comb begin
        unique case (code)
            3'b000:          mode = MD_HIZ;
            3'b001, 3'b101:  mode = MD_RSVD;
            3'b100:          mode = MD_TEST;
            3'b010, 3'b110:  mode = MD_NORM;
            3'b011, 3'b111:  mode = MD_NORM48;
            default:         mode = MD_HIZ;
        endcase
    end

endmodule

// File: rtl/clkgate_divider.sv
module clkgate_divider #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/clkgate_lane.sv
module clkgate_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic src,     // selected source level for this group
    input  logic want,    // requested gate state (1 = pass)
    input  logic settle,  // park low while the mode switches
    input  logic drive,   // output-enable requested by mode / power
    output logic en_q,
    output logic out_q,
    output logic oe_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            out_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            // gate only moves while the source sits low
            if (!src)
                en_q <= want;
            out_q <= settle ? 1'b0 : (src & en_q);
            oe_q  <= settle ? 1'b1 : drive;
        end
    end

endmodule

// File: rtl/clk_mode_gate.sv
module clk_mode_gate
    import clkgate_pkg::*;
#(
    parameter int SETTLE_CYC = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      sel,
    input  logic            pwr_up,
    input  logic            cpu_hold_n,
    input  logic            pci_hold_n,
    input  logic [NGRP-1:0] grp_src,
    input  logic [1:0]      alt_src,
    output logic [NGRP-1:0] clk_out,
    output logic [NGRP-1:0] clk_oe
);

    localparam int HOLD_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

    mode_e             mode_d;
    mode_e             mode_q;
    fsm_e              state_q;
    logic              rate_q;
    logic [HOLD_W-1:0] hold_q;
    logic [DIV_W-1:0]  cnt_w;

    logic              settle_w;
    logic              hiz_run_w;
    logic [NGRP-1:0]   pass_w;
    logic [NGRP-1:0]   src_w;
    logic [NGRP-1:0]   want_w;
    logic [NGRP-1:0]   drive_w;
    logic [NGRP-1:0]   en_w;

    clkgate_decode u_dec (
        .code (sel),
        .mode (mode_d)
    );

    // state register: T_CHANGE from any state, T_DONE out of ST_SETTLE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            mode_q  <= MD_HIZ;
            rate_q  <= 1'b0;
            hold_q  <= '0;
        end else if (mode_d != mode_q || sel[2] != rate_q) begin
            state_q <= ST_SETTLE;
            mode_q  <= mode_d;
            rate_q  <= sel[2];
            hold_q  <= '0;
        end else begin
            unique case (state_q)
                ST_SETTLE: begin
                    if (hold_q == HOLD_W'(SETTLE_CYC - 1))
                        state_q <= ST_RUN;
                    else
                        hold_q <= hold_q + 1'b1;
                end
                ST_RUN: hold_q <= '0;
            endcase
        end
    end

    clkgate_divider #(.W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (settle_w || mode_q != MD_TEST),
        .cnt   (cnt_w)
    );

    // per-group source, gate request and enable, from the stored mode
    always_comb begin
        settle_w  = (state_q == ST_SETTLE);
        hiz_run_w = !settle_w && (mode_q == MD_HIZ || mode_q == MD_RSVD);
        pass_w    = grp_src;
        if (rate_q)
            pass_w[1:0] = alt_src;
        for (int g = 0; g < NGRP; g++) begin
            logic mode_oe;
            unique case (mode_q)
                MD_TEST: begin
                    mode_oe  = 1'b1;
                    src_w[g] = cnt_w[div_tap(g)];
                end
                MD_NORM48: begin
                    mode_oe  = 1'b1;
                    src_w[g] = pass_w[g];
                end
                MD_NORM: begin
                    mode_oe  = (g != G_F48);
                    src_w[g] = (g != G_F48) && pass_w[g];
                end
                default: begin
                    mode_oe  = 1'b0;
                    src_w[g] = 1'b0;
                end
            endcase
            if (settle_w)
                src_w[g] = 1'b0;
            want_w[g]  = pwr_up
                       && !(!cpu_hold_n && (g == G_CPU || g == G_M66))
                       && !(!pci_hold_n && g == G_PCI);
            drive_w[g] = !pwr_up || mode_oe;
        end
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_lane
        clkgate_lane u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .src    (src_w[g]),
            .want   (want_w[g]),
            .settle (settle_w),
            .drive  (drive_w[g]),
            .en_q   (en_w[g]),
            .out_q  (clk_out[g]),
            .oe_q   (clk_oe[g])
        );
    end

endmodule

// File: rtl/clkgate_chk.sv
module clkgate_chk #(
    parameter int NGRP = 8,
    parameter int CW   = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pwr_up,
    input logic            settle,
    input logic            hiz_run,
    input logic [NGRP-1:0] src,
    input logic [NGRP-1:0] en,
    input logic [NGRP-1:0] out,
    input logic [NGRP-1:0] oe,
    input logic [CW-1:0]   cnt
);

    // R10: settle window parks everything low and driven
    p_settle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        settle |=> (out == '0 && oe == '1));

    // R6: power-down turns every driver on
    p_pwrdn_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_up |=> (oe == '1));

    // R2: tri-state and reserved codes float every output
    p_hiz_float_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hiz_run && pwr_up) |=> (oe == '0));

    // R3: divider restarts from zero after a mode switch
    p_cnt_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        settle |=> (cnt == '0));

    for (genvar g = 0; g < NGRP; g++) begin : g_prop
        // R9: gate moves only while its source is low
        p_gate_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (en[g] != $past(en[g])) |-> !$past(src[g]));
        // R7: a rising output needs an open gate
        p_rise_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(out[g]) |-> $past(en[g]));
    end

endmodule

bind clk_mode_gate clkgate_chk #(
    .NGRP (clkgate_pkg::NGRP),
    .CW   (clkgate_pkg::DIV_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr_up  (pwr_up),
    .settle  (settle_w),
    .hiz_run (hiz_run_w),
    .src     (src_w),
    .en      (en_w),
    .out     (clk_out),
    .oe      (clk_oe),
    .cnt     (cnt_w)
);

// File: tb/sim_clk_mode_gate.sv
module sim_clk_mode_gate;

    localparam int NG     = 8;
    localparam int SETTLE = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    sel = 3'b000;
    logic          pwr_up = 1'b1;
    logic          cpu_hold_n = 1'b1;
    logic          pci_hold_n = 1'b1;
    logic [NG-1:0] grp_src = '0;
    logic [1:0]    alt_src = '0;
    logic [NG-1:0] clk_out;
    logic [NG-1:0] clk_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_on = 0;

    clk_mode_gate #(.SETTLE_CYC(SETTLE)) u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .pwr_up(pwr_up),
        .cpu_hold_n(cpu_hold_n), .pci_hold_n(pci_hold_n),
        .grp_src(grp_src), .alt_src(alt_src),
        .clk_out(clk_out), .clk_oe(clk_oe)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- source clocks (half periods per group) ----------------
    function automatic int half_p(input int g);
        case (g)
            0: return 3;  1: return 4;  2: return 2;  3: return 5;
            4: return 5;  5: return 2;  6: return 1;  default: return 6;
        endcase
    endfunction

    int tick = 0;
    always @(negedge clk) begin
        tick++;
        for (int g = 0; g < NG; g++) grp_src[g] <= ((tick / half_p(g)) % 2) == 1;
        alt_src[0] <= ((tick / 2) % 2) == 1;
        alt_src[1] <= ((tick / 3) % 2) == 1;
    end

    // ---------------- behavioural reference model ----------------
    int    m_mode, m_cnt, m_hold;
    bit    m_rate, m_settle;
    bit    m_en[NG], m_out[NG], m_oe[NG];
    string m_tag[NG];

    function automatic int mode_of(input logic [2:0] c);
        case (c)
            3'd0: return 0;
            3'd1, 3'd5: return 1;
            3'd4: return 4;
            3'd2, 3'd6: return 2;
            default: return 3;
        endcase
    endfunction

    // test-mode period in clk cycles per group
    function automatic int test_period(input int g);
        case (g)
            6: return 2;  0, 5: return 4;  1, 2: return 8;  3, 4: return 16;
            default: return 32;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_rate = 0; m_settle = 0; m_hold = 0; m_cnt = 0;
            for (int g = 0; g < NG; g++) begin
                m_en[g] = 0; m_out[g] = 0; m_oe[g] = 0; m_tag[g] = "R1";
            end
        end else begin
            int dec;
            bit chg;
            dec = mode_of(sel);
            chg = (dec != m_mode) || (sel[2] != m_rate);
            for (int g = 0; g < NG; g++) begin
                bit s, w, mo, pv;
                pv = (m_rate && g < 2) ? alt_src[g] : grp_src[g];
                s = 0;
                if (!m_settle) begin
                    if (m_mode == 4) s = ((m_cnt / (test_period(g) / 2)) % 2) == 1;
                    else if (m_mode == 3) s = pv;
                    else if (m_mode == 2) s = (g != 5) && pv;
                end
                w  = pwr_up && !(!cpu_hold_n && (g == 0 || g == 2)) && !(!pci_hold_n && g == 3);
                mo = (m_mode == 2) ? (g != 5) : (m_mode == 3 || m_mode == 4);
                if (m_settle)                         m_tag[g] = "R10";
                else if (!pwr_up)                     m_tag[g] = "R6";
                else if (m_mode == 4)                 m_tag[g] = "R3";
                else if (m_mode < 2)                  m_tag[g] = "R2";
                else if (m_rate && g < 2)             m_tag[g] = "R5";
                else if (!cpu_hold_n && (g == 0 || g == 2)) m_tag[g] = "R7";
                else if (!pci_hold_n && (g == 3 || g == 4)) m_tag[g] = "R8";
                else if (g == 5)                      m_tag[g] = "R4";
                else                                  m_tag[g] = "R11";
                m_out[g] = m_settle ? 1'b0 : (s && m_en[g]);
                m_oe[g]  = m_settle ? 1'b1 : (!pwr_up || mo);
                if (!s) m_en[g] = w;
            end
            m_cnt = (m_settle || m_mode != 4) ? 0 : (m_cnt + 1) % 32;
            if (chg) begin
                m_mode = dec; m_rate = sel[2]; m_settle = 1; m_hold = 0;
            end else if (m_settle) begin
                if (m_hold == SETTLE - 1) m_settle = 0;
                else m_hold++;
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            for (int g = 0; g < NG; g++) begin
                chk(clk_out[g] == m_out[g], m_tag[g], clk_out[g], m_out[g]);
                chk(clk_oe[g] == m_oe[g], m_tag[g], clk_oe[g], m_oe[g]);
            end
        end
    end

    // ---------------- pulse-width monitor for R9 ----------------
    bit mon_on = 0;
    int run0 = -1, run3 = -1;
    always @(negedge clk) begin
        if (!mon_on) begin
            run0 = -1; run3 = -1;
        end else begin
            if (clk_out[0]) begin if (run0 >= 0) run0++; end
            else begin
                if (run0 > 0) chk(run0 == 3, "R9 cpu pulse", run0, 3);
                run0 = 0;
            end
            if (clk_out[3]) begin if (run3 >= 0) run3++; end
            else begin
                if (run3 > 0) chk(run3 == 5, "R9 pci pulse", run3, 5);
                run3 = 0;
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    bit finished = 0;

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            report();
        end
    end

    initial begin
        wait_cyc(4);
        // R1: reset state
        chk(clk_out == '0, "R1 out", clk_out, 0);
        chk(clk_oe == '0, "R1 oe", clk_oe, 0);
        rst_n = 1'b1;
        cmp_on = 1;

        // sweep every code with every power/stop combination
        for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < 8; k++) begin
                sel        = 3'(c);
                pwr_up     = k[2];
                cpu_hold_n = k[1];
                pci_hold_n = k[0];
                wait_cyc(30);
            end
        end
        pwr_up = 1; cpu_hold_n = 1; pci_hold_n = 1;

        // R3: divide ratios in test mode
        sel = 3'b100;
        wait_cyc(6);
        begin
            int rises[NG];
            logic [NG-1:0] prev;
            for (int g = 0; g < NG; g++) rises[g] = 0;
            prev = clk_out;
            for (int i = 0; i < 64; i++) begin
                wait_cyc(1);
                for (int g = 0; g < NG; g++) if (clk_out[g] && !prev[g]) rises[g]++;
                prev = clk_out;
            end
            for (int g = 0; g < NG; g++)
                chk(rises[g] == 64 / test_period(g), "R3 ratio", rises[g], 64 / test_period(g));
        end

        // R4: 48 MHz enable off, then on
        sel = 3'b010;
        wait_cyc(6);
        chk(clk_oe == 8'b1101_1111, "R4 48 off", clk_oe, 8'hDF);
        sel = 3'b011;
        wait_cyc(6);
        chk(clk_oe == 8'hFF, "R4 48 on", clk_oe, 8'hFF);

        // R2: reserved code floats
        sel = 3'b101;
        wait_cyc(6);
        chk(clk_oe == 8'h00, "R2 reserved", clk_oe, 0);

        // R8: PCI held, free-running PCI continues
        sel = 3'b011;
        pci_hold_n = 0;
        wait_cyc(15);
        begin
            int hi3, rise4;
            logic p4;
            hi3 = 0; rise4 = 0; p4 = clk_out[4];
            for (int i = 0; i < 40; i++) begin
                wait_cyc(1);
                if (clk_out[3]) hi3++;
                if (clk_out[4] && !p4) rise4++;
                p4 = clk_out[4];
            end
            chk(hi3 == 0, "R8 pci held", hi3, 0);
            chk(rise4 >= 3, "R8 pcif runs", rise4, 4);
        end
        pci_hold_n = 1;

        // R9: toggling stops never cut a pulse
        sel = 3'b010;
        wait_cyc(6);
        mon_on = 1;
        for (int i = 0; i < 160; i++) begin
            if (i % 7 == 0) cpu_hold_n = ~cpu_hold_n;
            if (i % 11 == 0) pci_hold_n = ~pci_hold_n;
            wait_cyc(1);
        end
        mon_on = 0;
        cpu_hold_n = 1; pci_hold_n = 1;
        wait_cyc(10);

        finished = 1;
        report();
    end

endmodule